// File: doc/BRIEF.md
# GPIO Controller with Edge Interrupts

This block is a memory-mapped general-purpose I/O controller for 32 pins. Software programs each pin's direction and drives output levels through separate write-one-to-set and write-one-to-clear ports, so no read-modify-write is needed to change a single pin. Every pin input passes through a two-flop synchronizer. The synchronized level can always be read back, including on pins that are configured as outputs.

Each pin has a rising-edge enable mask and a falling-edge enable mask, and each mask has its own set port and clear port. An enabled edge latches a bit in a status register, and writing 1 to a status bit clears it. The status register is split into two 16-pin banks. Each bank drives a level interrupt that is gated by a bank-enable bit. The lowest pins can also drive one dedicated interrupt line each, which pulses for one cycle on every enabled edge. This suits an interrupt controller that takes per-pin requests directly.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset every pin is an input (direction reads 0xFFFFFFFF, pin_oe is 0), the output latch, both edge masks, the status register and the bank enables read 0, and all interrupt outputs are low.
- R2: The direction register at 0x10 is read/write, and a bit of 1 makes the pin an input. pin_oe is the inverse of the direction register.
- R3: A write to 0x18 sets every output-latch bit whose write-data bit is 1, and a write to 0x1C clears every such bit. Bits written as 0 keep their value. Writes to 0x14 are ignored. Reads of 0x14, 0x18 and 0x1C return the latch, which drives pin_out.
- R4: Reading 0x20 returns the pin level delayed by two clock edges, whether the pin is an input or an output. A read made before those edges returns the old level.
- R5: The rising mask is set through 0x24 and cleared through 0x28. The falling mask is set through 0x2C and cleared through 0x30. Reading either port of a pair returns the current mask.
- R6: A synchronized 0-to-1 change on a pin with its rising bit set, or a 1-to-0 change with its falling bit set, sets that pin's bit in the status register at 0x34. With both bits set, both edges are detected. An edge on a pin with neither bit set leaves status unchanged.
- R7: Writing 0x34 clears the status bits written as 1 and leaves the others unchanged.
- R8: If an edge event and a clear write hit the same status bit on the same clock edge, the bit stays set.
- R9: bank_irq[0] is high exactly when any of status bits 15:0 is set and bank-enable bit 0 is set. bank_irq[1] does the same for bits 31:16 and bank-enable bit 1. Both outputs are levels. The bank enables are read/write at 0x08, bits 1:0.
- R10: For each pin below NDIRECT (default 8), direct_irq pulses high for one cycle in the cycle before the status bit sets, and only on an edge that the masks enable. Pins at or above NDIRECT produce no direct pulse.
- R11: Addresses outside the map read as 0, and writes to them (or to the read-only 0x20) change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Output latch value |
| pin_oe | output | 32 | Output enable per pin (1 = drive) |
| bank_irq | output | 2 | Level interrupt per 16-pin bank |
| direct_irq | output | 8 | One-cycle edge pulse per low pin |

## Verification
The hardest case to reach is a status clear that lands on exactly the clock edge where a new edge event is latched. The pin change must be placed two synchronizer stages ahead of the bus write. The bench changes the pin on a falling clock edge, waits two further falling edges, and only then issues the clear. The write then takes effect on the same rising edge that records the event, and the bench reads the bit back to confirm it survived. A cycle-level model in the bench follows the synchronizer delay independently, so every other overlap of edges and writes is compared on each clock as well.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam int REG_AW = 8;

  localparam logic [REG_AW-1:0] A_BANK_EN   = 8'h08;
  localparam logic [REG_AW-1:0] A_DIR       = 8'h10;
  localparam logic [REG_AW-1:0] A_OUT       = 8'h14;
  localparam logic [REG_AW-1:0] A_OUT_SET   = 8'h18;
  localparam logic [REG_AW-1:0] A_OUT_CLR   = 8'h1C;
  localparam logic [REG_AW-1:0] A_IN        = 8'h20;
  localparam logic [REG_AW-1:0] A_RISE_SET  = 8'h24;
  localparam logic [REG_AW-1:0] A_RISE_CLR  = 8'h28;
  localparam logic [REG_AW-1:0] A_FALL_SET  = 8'h2C;
  localparam logic [REG_AW-1:0] A_FALL_CLR  = 8'h30;
  localparam logic [REG_AW-1:0] A_STATUS    = 8'h34;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_BANK_EN, SEL_DIR, SEL_OUT, SEL_OUT_SET, SEL_OUT_CLR,
    SEL_IN, SEL_RISE_SET, SEL_RISE_CLR, SEL_FALL_SET, SEL_FALL_CLR, SEL_STATUS
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [REG_AW-1:0] a);
    case (a)
      A_BANK_EN:  return SEL_BANK_EN;
      A_DIR:      return SEL_DIR;
      A_OUT:      return SEL_OUT;
      A_OUT_SET:  return SEL_OUT_SET;
      A_OUT_CLR:  return SEL_OUT_CLR;
      A_IN:       return SEL_IN;
      A_RISE_SET: return SEL_RISE_SET;
      A_RISE_CLR: return SEL_RISE_CLR;
      A_FALL_SET: return SEL_FALL_SET;
      A_FALL_CLR: return SEL_FALL_CLR;
      A_STATUS:   return SEL_STATUS;
      default:    return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] sync_q,
  output logic [W-1:0] prev_q
);
  logic [W-1:0] meta_q;

  // Per-pin two-stage synchronizer plus one history stage for edge compare
  for (genvar i = 0; i < W; i++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[i] <= 1'b0;
        sync_q[i] <= 1'b0;
        prev_q[i] <= 1'b0;
      end else begin
        meta_q[i] <= pin_in[i];
        sync_q[i] <= meta_q[i];
        prev_q[i] <= sync_q[i];
      end
    end
  end
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_pkg::*;
#(
  parameter int W     = 32,
  parameter int NBANK = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  reg_sel_e         sel,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     dir_q,
  output logic [W-1:0]     out_q,
  output logic [W-1:0]     rise_q,
  output logic [W-1:0]     fall_q,
  output logic [NBANK-1:0] ben_q
);
  // Atomic update helper: set bits, then clear bits
  function automatic logic [W-1:0] set_clr(input logic [W-1:0] cur,
                                           input logic [W-1:0] s,
                                           input logic [W-1:0] c);
    return (cur | s) & ~c;
  endfunction

  logic [W-1:0] zero_w;
  assign zero_w = '0;

  logic [W-1:0] out_s, out_c, rise_s, rise_c, fall_s, fall_c;
  assign out_s  = (wr_en && sel == SEL_OUT_SET)  ? wdata : zero_w;
  assign out_c  = (wr_en && sel == SEL_OUT_CLR)  ? wdata : zero_w;
  assign rise_s = (wr_en && sel == SEL_RISE_SET) ? wdata : zero_w;
  assign rise_c = (wr_en && sel == SEL_RISE_CLR) ? wdata : zero_w;
  assign fall_s = (wr_en && sel == SEL_FALL_SET) ? wdata : zero_w;
  assign fall_c = (wr_en && sel == SEL_FALL_CLR) ? wdata : zero_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '1;
      out_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      ben_q  <= '0;
    end else begin
      if (wr_en && sel == SEL_DIR)     dir_q <= wdata;
      if (wr_en && sel == SEL_BANK_EN) ben_q <= wdata[NBANK-1:0];
      out_q  <= set_clr(out_q,  out_s,  out_c);
      rise_q <= set_clr(rise_q, rise_s, rise_c);
      fall_q <= set_clr(fall_q, fall_s, fall_c);
    end
  end
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
  parameter int W         = 32,
  parameter int BANK_W    = 16,
  parameter int NBANK     = 2,
  parameter int NDIRECT   = 8,
  parameter bit DIRECT_EN = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [W-1:0]       sync_q,
  input  logic [W-1:0]       prev_q,
  input  logic [W-1:0]       rise_q,
  input  logic [W-1:0]       fall_q,
  input  logic [NBANK-1:0]   ben_q,
  input  logic [W-1:0]       clr_mask,
  output logic [W-1:0]       edge_evt,
  output logic [W-1:0]       status_q,
  output logic [NBANK-1:0]   bank_irq,
  output logic [NDIRECT-1:0] direct_irq
);
  function automatic logic [W-1:0] edge_events(input logic [W-1:0] cur,
                                               input logic [W-1:0] old,
                                               input logic [W-1:0] ren,
                                               input logic [W-1:0] fen);
    return (cur & ~old & ren) | (~cur & old & fen);
  endfunction

  // A new event outranks a clear on the same bit
  function automatic logic [W-1:0] next_status(input logic [W-1:0] cur,
                                               input logic [W-1:0] clr,
                                               input logic [W-1:0] ev);
    return (cur & ~clr) | ev;
  endfunction

  assign edge_evt = edge_events(sync_q, prev_q, rise_q, fall_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= next_status(status_q, clr_mask, edge_evt);
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign bank_irq[b] = ben_q[b] & (|status_q[b*BANK_W +: BANK_W]);
  end

  if (DIRECT_EN) begin : g_direct
    assign direct_irq = edge_evt[NDIRECT-1:0];
  end else begin : g_no_direct
    assign direct_irq = '0;
  end
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_pkg::*;
#(
  parameter int NPIN      = 32,
  parameter int BANK_W    = 16,
  parameter int NDIRECT   = 8,
  parameter bit DIRECT_EN = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [REG_AW-1:0]     bus_addr,
  input  logic                  bus_wr,
  input  logic [NPIN-1:0]       bus_wdata,
  output logic [NPIN-1:0]       bus_rdata,
  input  logic [NPIN-1:0]       pin_in,
  output logic [NPIN-1:0]       pin_out,
  output logic [NPIN-1:0]       pin_oe,
  output logic [NPIN/BANK_W-1:0] bank_irq,
  output logic [NDIRECT-1:0]    direct_irq
);
  localparam int NBANK = NPIN / BANK_W;

  reg_sel_e          sel;
  logic [NPIN-1:0]   sync_q, prev_q, dir_q, out_q, rise_q, fall_q;
  logic [NPIN-1:0]   status_q, edge_evt, clr_mask;
  logic [NBANK-1:0]  ben_q;

  assign sel = decode_addr(bus_addr);

  gpio_in_sync #(.W(NPIN)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
    .sync_q(sync_q), .prev_q(prev_q)
  );

  gpio_regfile #(.W(NPIN), .NBANK(NBANK)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .sel(sel), .wdata(bus_wdata),
    .dir_q(dir_q), .out_q(out_q), .rise_q(rise_q), .fall_q(fall_q),
    .ben_q(ben_q)
  );

  assign clr_mask = (bus_wr && sel == SEL_STATUS) ? bus_wdata : '0;

  gpio_irq_status #(
    .W(NPIN), .BANK_W(BANK_W), .NBANK(NBANK),
    .NDIRECT(NDIRECT), .DIRECT_EN(DIRECT_EN)
  ) u_irq (
    .clk(clk), .rst_n(rst_n), .sync_q(sync_q), .prev_q(prev_q),
    .rise_q(rise_q), .fall_q(fall_q), .ben_q(ben_q), .clr_mask(clr_mask),
    .edge_evt(edge_evt), .status_q(status_q), .bank_irq(bank_irq),
    .direct_irq(direct_irq)
  );

  always_comb begin
    bus_rdata = '0;
    case (sel)
      SEL_BANK_EN:                       bus_rdata[NBANK-1:0] = ben_q;
      SEL_DIR:                           bus_rdata = dir_q;
      SEL_OUT, SEL_OUT_SET, SEL_OUT_CLR: bus_rdata = out_q;
      SEL_IN:                            bus_rdata = sync_q;
      SEL_RISE_SET, SEL_RISE_CLR:        bus_rdata = rise_q;
      SEL_FALL_SET, SEL_FALL_CLR:        bus_rdata = fall_q;
      SEL_STATUS:                        bus_rdata = status_q;
      default:                           bus_rdata = '0;
    endcase
  end

  assign pin_out = out_q;
  assign pin_oe  = ~dir_q;
endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
module gpio_edge_ctrl_chk
  import gpio_pkg::*;
#(
  parameter int NPIN    = 32,
  parameter int BANK_W  = 16,
  parameter int NDIRECT = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [REG_AW-1:0]      bus_addr,
  input logic                   bus_wr,
  input logic [NPIN-1:0]        bus_wdata,
  input logic [NPIN-1:0]        out_q,
  input logic [NPIN-1:0]        status_q,
  input logic [NPIN-1:0]        edge_evt,
  input logic [NPIN/BANK_W-1:0] ben_q,
  input logic [NPIN/BANK_W-1:0] bank_irq,
  input logic [NDIRECT-1:0]     direct_irq
);
  assert_set_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_OUT_SET) |=> ((out_q & $past(bus_wdata)) == $past(bus_wdata)));

  assert_clr_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_OUT_CLR) |=> ((out_q & $past(bus_wdata)) == '0));

  assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_STATUS && edge_evt == '0) |=> ((status_q & $past(bus_wdata)) == '0));

  assert_event_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_evt != '0) |=> ((status_q & $past(edge_evt)) == $past(edge_evt)));

  assert_bank_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((bank_irq & ~ben_q) == '0));

  assert_bank_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bank_irq[0] |-> (status_q[BANK_W-1:0] != '0));

  assert_direct_latched_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (direct_irq != '0) |=> ((status_q[NDIRECT-1:0] & $past(direct_irq)) == $past(direct_irq)));
endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(
  .NPIN(NPIN), .BANK_W(BANK_W), .NDIRECT(NDIRECT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .out_q(out_q), .status_q(status_q),
  .edge_evt(edge_evt), .ben_q(ben_q), .bank_irq(bank_irq),
  .direct_irq(direct_irq)
);

// File: tb/sim_gpio_edge_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_edge_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic [1:0]  bank_irq;
  logic [7:0]  direct_irq;

  always #2.5 clk = ~clk;

  gpio_edge_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .bank_irq(bank_irq),
    .direct_irq(direct_irq)
  );

  int checks = 0, fails = 0;
  bit done = 0, live = 0;
  int pulses5 = 0, pulses6 = 0;

  // Behavioural reference: plain vectors, a queue for the input delay line
  logic [31:0] m_dir = '1, m_out = '0, m_rise = '0, m_fall = '0, m_stat = '0;
  logic [1:0]  m_ben = '0;
  logic [31:0] m_dly[$] = '{32'h0, 32'h0, 32'h0};  // [0]=newest ... [2]=previous

  function automatic logic [31:0] m_events();
    logic [31:0] now_v = m_dly[1];
    logic [31:0] old_v = m_dly[2];
    logic [31:0] ev = '0;
    for (int i = 0; i < 32; i++) begin
      if (now_v[i] && !old_v[i] && m_rise[i]) ev[i] = 1'b1;
      if (!now_v[i] && old_v[i] && m_fall[i]) ev[i] = 1'b1;
    end
    return ev;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_dir = '1; m_out = '0; m_rise = '0; m_fall = '0; m_stat = '0; m_ben = '0;
      m_dly = '{32'h0, 32'h0, 32'h0};
    end else begin
      logic [31:0] ev;
      ev = m_events();
      if (bus_wr && bus_addr == 8'h34) m_stat = m_stat & ~bus_wdata;
      m_stat = m_stat | ev;
      if (bus_wr) begin
        case (bus_addr)
          8'h08: m_ben = bus_wdata[1:0];
          8'h10: m_dir = bus_wdata;
          8'h18: m_out = m_out | bus_wdata;
          8'h1C: m_out = m_out & ~bus_wdata;
          8'h24: m_rise = m_rise | bus_wdata;
          8'h28: m_rise = m_rise & ~bus_wdata;
          8'h2C: m_fall = m_fall | bus_wdata;
          8'h30: m_fall = m_fall & ~bus_wdata;
          default: ;
        endcase
      end
      m_dly.push_front(pin_in);
      void'(m_dly.pop_back());
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Compare outputs every clock, away from the rising edge
  always @(negedge clk) begin
    if (live) begin
      logic [31:0] ev;
      logic [1:0]  eb;
      ev = m_events();
      eb[0] = m_ben[0] & (|m_stat[15:0]);
      eb[1] = m_ben[1] & (|m_stat[31:16]);
      check("R3 pin_out", pin_out, m_out);
      check("R2 pin_oe", pin_oe, ~m_dir);
      check("R9 bank_irq", {30'h0, bank_irq}, {30'h0, eb});
      check("R10 direct_irq", {24'h0, direct_irq}, {24'h0, ev[7:0]});
      if (direct_irq[5]) pulses5++;
      if (direct_irq[6]) pulses6++;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a;
    #1;
    check(tag, bus_rdata, exp);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #500000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    live = 1;
    // R1 reset state
    rd(8'h10, 32'hFFFF_FFFF, "R1 dir");
    rd(8'h14, 32'h0, "R1 out");
    rd(8'h24, 32'h0, "R1 rise");
    rd(8'h2C, 32'h0, "R1 fall");
    rd(8'h34, 32'h0, "R1 status");
    rd(8'h08, 32'h0, "R1 bank_en");
    check("R1 irq lines", {22'h0, bank_irq, direct_irq}, 32'h0);
    // R2 direction
    wr(8'h10, 32'h0000_FFFF);
    rd(8'h10, 32'h0000_FFFF, "R2 dir readback");
    check("R2 pin_oe", pin_oe, 32'hFFFF_0000);
    // R3 set/clear data
    wr(8'h18, 32'hF0F0_0001);
    wr(8'h1C, 32'h00F0_0000);
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h14, 32'hF000_0001, "R3 out_data");
    rd(8'h18, 32'hF000_0001, "R3 set port read");
    rd(8'h1C, 32'hF000_0001, "R3 clr port read");
    // R4 input sync, including output pin 0
    pin_in = 32'h0000_00A5;
    bus_addr = 8'h20; #1;
    check("R4 in_data old", bus_rdata, 32'h0);
    idle(2);
    rd(8'h20, 32'h0000_00A5, "R4 in_data new");
    // R5 masks
    wr(8'h24, 32'h0010_000F);
    rd(8'h24, 32'h0010_000F, "R5 rise set");
    wr(8'h28, 32'h0000_0003);
    rd(8'h28, 32'h0010_000C, "R5 rise clr");
    wr(8'h2C, 32'h0000_0108);
    rd(8'h30, 32'h0000_0108, "R5 fall read");
    // R6 edges: pin3 and pin20 rise, pin2 unchanged
    pin_in = pin_in | 32'h0010_0008;
    idle(4);
    rd(8'h34, 32'h0010_0008, "R6 rising");
    wr(8'h34, 32'h0010_0008);
    rd(8'h34, 32'h0, "R7 cleared");
    pin_in = pin_in & ~32'h8;          // pin3 falls, both edges enabled
    idle(4);
    rd(8'h34, 32'h0000_0008, "R6 falling both");
    pin_in = pin_in | 32'h100;         // pin8 rises, only falling enabled
    idle(4);
    rd(8'h34, 32'h0000_0008, "R6 masked edge");
    pin_in = pin_in & ~32'h100;
    idle(4);
    rd(8'h34, 32'h0000_0108, "R6 pin8 fall");
    // R7 partial clear
    wr(8'h34, 32'h0000_0100);
    rd(8'h34, 32'h0000_0008, "R7 partial clear");
    wr(8'h34, 32'h0000_0008);
    rd(8'h34, 32'h0, "R7 full clear");
    // R8 clear on the same edge the event lands
    pin_in = pin_in | 32'h8;
    idle(2);
    wr(8'h34, 32'h0000_0008);
    rd(8'h34, 32'h0000_0008, "R8 event wins");
    wr(8'h34, 32'h0000_0008);
    rd(8'h34, 32'h0, "R8 later clear");
    // R9 banks
    wr(8'h08, 32'h2);
    rd(8'h08, 32'h2, "R9 bank_en read");
    pin_in = pin_in & ~32'h0010_0004;
    idle(4);
    pin_in = pin_in | 32'h0010_0004;
    idle(4);
    rd(8'h34, 32'h0010_0004, "R9 status");
    check("R9 only bank1", {30'h0, bank_irq}, 32'h2);
    wr(8'h08, 32'h3);
    idle(1);
    check("R9 both banks", {30'h0, bank_irq}, 32'h3);
    wr(8'h34, 32'h0010_0000);
    idle(1);
    check("R9 bank1 drained", {30'h0, bank_irq}, 32'h1);
    wr(8'h34, 32'h0000_0004);
    // R10 direct lines
    wr(8'h24, 32'h0000_1020);
    pin_in = pin_in & ~32'h0000_1060;
    idle(4);
    pulses5 = 0; pulses6 = 0;
    pin_in = pin_in | 32'h0000_1060;
    idle(5);
    check("R10 pin5 one pulse", pulses5, 1);
    check("R10 pin6 masked", pulses6, 0);
    rd(8'h34, 32'h0000_1020, "R10 status pin5 pin12");
    // R11 unmapped and read-only
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h40, 32'h0, "R11 unmapped read");
    rd(8'h04, 32'h0, "R11 unmapped read 2");
    rd(8'h10, 32'h0000_FFFF, "R11 dir intact");
    rd(8'h20, pin_in, "R11 in_data intact");
    idle(2);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule